// File: doc/BRIEF.md
# Frame-Synchronized Image Byte FIFO

This block buffers image bytes (raw pixels or compressed stream) on their way from a capture pipeline to a host processor or a DMA engine. The producer presents one byte per cycle on a write strobe. Bytes are accepted only while the frame-valid envelope input is high. The host takes bytes one at a time by reading a data port. Each read returns the oldest stored byte, and a read of an empty buffer returns the last byte delivered again. The block keeps a live fill count. An interrupt is active while that count is at or above a software threshold.

At every rising edge of the frame envelope the buffer empties itself, so each frame starts clean. Bytes left over from the previous frame, and bytes that arrive while the buffer is full, set a sticky error bit. Software clears that bit by writing to a clear port. One control byte holds the DMA burst size, the DMA enable, and the output polarities of the interrupt and DMA-request pins. A self-clearing bit in the same byte flushes the buffer on demand.

The DMA request is governed by a three-state machine. `DMA_OFF` is entered whenever the DMA mode is zero. `OFF→WAIT` happens when a non-zero mode is set. `WAIT→BURST` happens when the fill count reaches the burst length. `BURST→WAIT` happens when the burst's last byte is popped or when the buffer is flushed. From either `WAIT` or `BURST`, the machine returns to `OFF` when the mode returns to zero. The request is active only in `BURST`.

Top module: `frame_byte_fifo`

## Requirements
- R1: Each accepted pop returns the oldest stored byte on `rd_data` in the cycle after the pop strobe, and `fill_level` drops by one.
- R2: A pop while `fill_level` is 0 leaves `rd_data` at the last popped byte and `fill_level` at 0.
- R3: A write strobe while `frame_valid` is low stores nothing.
- R4: In the first cycle `frame_valid` is high after being low, the buffer is emptied. `err_flag` is set if the buffer held any byte and left unchanged if it was empty. A byte written in that same cycle becomes the first byte of the new frame.
- R5: A write while `fill_level` is 64 with no pop in the same cycle is dropped, and it sets `err_flag`.
- R6: `err_flag` stays set until `clr_wr` is strobed with `clr_wdata[0]`=1. A strobe with bit 0 at 0 leaves it set.
- R7: The interrupt is active while `fill_level` ≥ the 6-bit threshold (reset value 32). `irq_o` equals that level when control bit 5 is 0 and its inverse when bit 5 is 1.
- R8: Control bits 3:2 select the DMA mode: 00 is off with `drq_oe`=0; 01, 10 and 11 select bursts of 8, 16 and 32 bytes. The request becomes active one cycle after `fill_level` reaches the burst length. It stays active until that many bytes are popped, or until a flush. `drq_o` is inverted when control bit 4 is 1.
- R9: A control write with bit 0 set empties the buffer at once without setting `err_flag`. Control read-back bits 7:6, 1 and 0 are always 0.
- R10: A write and a pop in the same cycle leave `fill_level` unchanged, including when the buffer is full, and set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Vertical frame envelope from the producer |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 8 | Producer byte |
| rd_en | input | 1 | Host pop strobe for the data port |
| rd_data | output | 8 | Last popped byte |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Control byte read-back |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 6 | Interrupt threshold value |
| clr_wr | input | 1 | Interrupt-clear write strobe |
| clr_wdata | input | 8 | Interrupt-clear value; bit 0 clears the error flag |
| fill_level | output | 7 | Bytes currently held (0..64) |
| err_flag | output | 1 | Sticky frame error flag |
| irq_o | output | 1 | Interrupt pin, polarity per control bit 5 |
| drq_o | output | 1 | DMA request pin, polarity per control bit 4 |
| drq_oe | output | 1 | Output enable for the DMA request pin; 0 releases the pin |

## Verification
Two sets of functions can meet in one cycle. The first is the producer's write and the host's pop, which is hardest when the buffer is exactly full. The second is the frame-start flush and a new byte arriving on the envelope edge. The bench fills the buffer to 64 and then raises the write and pop strobes on the same clock. The count must stay at 64, the oldest byte must come out, and the error bit must stay clear. It also raises the envelope and the write strobe in the same cycle. The count must read 1 afterwards, and the next pop must return that byte.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
    typedef enum logic [1:0] {
        DMA_OFF   = 2'd0,
        DMA_WAIT  = 2'd1,
        DMA_BURST = 2'd2
    } dma_state_t;

    localparam int unsigned CTRL_IRQ_POL = 5;
    localparam int unsigned CTRL_DRQ_POL = 4;
    localparam int unsigned CTRL_MODE_HI = 3;
    localparam int unsigned CTRL_MODE_LO = 2;
    localparam int unsigned CTRL_FLUSH   = 0;
endpackage

// File: rtl/ffb_store.sv
module ffb_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          soft_clr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          flush,
    output logic          rd_pop,
    output logic          drop_err,
    output logic          ovf_err
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          fv_q;
    logic          frame_start, empty, full, wr_ok;

    always_comb begin
        frame_start = frame_valid & ~fv_q;
        flush       = frame_start | soft_clr;
        empty       = (count == '0);
        full        = (count == CW'(DEPTH));
        rd_pop      = rd_en & ~empty & ~flush;
        wr_ok       = wr_en & frame_valid & (flush | ~full | rd_pop);
        ovf_err     = wr_en & frame_valid & full & ~rd_pop & ~flush;
        drop_err    = frame_start & ~empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fv_q  <= 1'b0;
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            fv_q <= frame_valid;
            if (flush) begin
                wptr  <= wr_ok ? AW'(1) : '0;
                rptr  <= '0;
                count <= wr_ok ? CW'(1) : '0;
            end else begin
                wptr  <= wptr + AW'(wr_ok);
                rptr  <= rptr + AW'(rd_pop);
                count <= count + CW'(wr_ok) - CW'(rd_pop);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[flush ? '0 : wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_pop) begin
            rd_data <= mem[rptr];
        end
    end

    // R1: count never exceeds the capacity
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2: a pop of an empty buffer leaves the data port unchanged
    p_empty_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count == '0) |=> $stable(rd_data));

    // R3: with the envelope low the count cannot grow
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> count <= $past(count));

    // R4: after a flush at most the same-cycle byte remains
    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count <= CW'(1));

    // R10: write and pop in one cycle keep the count
    p_simul_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && frame_valid && rd_en && count != '0 && !flush) |=> $stable(count));
endmodule

// File: rtl/ffb_regs.sv
module ffb_regs
    import ffb_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [7:0]    ctrl_wdata,
    input  logic          thr_wr,
    input  logic [AW-1:0] thr_wdata,
    input  logic          clr_wr,
    input  logic [7:0]    clr_wdata,
    input  logic          drop_err,
    input  logic          ovf_err,
    input  logic [CW-1:0] count,
    output logic [7:0]    ctrl_rdata,
    output logic          soft_clr,
    output logic          err_flag,
    output logic          irq_active,
    output logic          irq_pol,
    output logic          drq_pol,
    output logic [1:0]    dma_mode
);
    logic [AW-1:0] thr;
    logic          err_clr;

    always_comb begin
        soft_clr   = ctrl_wr & ctrl_wdata[CTRL_FLUSH];
        err_clr    = clr_wr & clr_wdata[0];
        irq_active = (count >= {1'b0, thr});
        ctrl_rdata = {2'b00, irq_pol, drq_pol, dma_mode, 2'b00};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pol  <= 1'b0;
            drq_pol  <= 1'b0;
            dma_mode <= 2'b00;
            thr      <= AW'(DEPTH / 2);
            err_flag <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                irq_pol  <= ctrl_wdata[CTRL_IRQ_POL];
                drq_pol  <= ctrl_wdata[CTRL_DRQ_POL];
                dma_mode <= ctrl_wdata[CTRL_MODE_HI:CTRL_MODE_LO];
            end
            if (thr_wr) begin
                thr <= thr_wdata;
            end
            if (drop_err || ovf_err) begin
                err_flag <= 1'b1;
            end else if (err_clr) begin
                err_flag <= 1'b0;
            end
        end
    end

    // R6: the error flag only falls on a clear strobe with bit 0 set
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(clr_wr && clr_wdata[0])) |=> err_flag);

    // R9: reserved and self-clearing bits read as zero
    p_ctrl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[7:6] == 2'b00 && ctrl_rdata[1:0] == 2'b00);
endmodule

// File: rtl/ffb_dma.sv
module ffb_dma
    import ffb_pkg::*;
#(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned BURST_BASE = 8,
    localparam int unsigned AW        = $clog2(DEPTH),
    localparam int unsigned CW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    dma_mode,
    input  logic [CW-1:0] count,
    input  logic          rd_pop,
    input  logic          flush,
    output logic          drq_active
);
    dma_state_t    state, nxt;
    logic [CW-1:0] blen, rem;

    always_comb begin
        unique case (dma_mode)
            2'b01:   blen = CW'(BURST_BASE);
            2'b10:   blen = CW'(BURST_BASE * 2);
            2'b11:   blen = CW'(BURST_BASE * 4);
            default: blen = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            DMA_OFF: begin
                if (dma_mode != 2'b00) nxt = DMA_WAIT;
            end
            DMA_WAIT: begin
                if (dma_mode == 2'b00)             nxt = DMA_OFF;
                else if (!flush && count >= blen)  nxt = DMA_BURST;
            end
            DMA_BURST: begin
                if (dma_mode == 2'b00)              nxt = DMA_OFF;
                else if (flush)                     nxt = DMA_WAIT;
                else if (rd_pop && rem == CW'(1))   nxt = DMA_WAIT;
            end
            default: nxt = DMA_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DMA_OFF;
            rem   <= '0;
        end else begin
            state <= nxt;
            if (state == DMA_WAIT && nxt == DMA_BURST) begin
                rem <= blen;
            end else if (state == DMA_BURST && rd_pop) begin
                rem <= rem - CW'(1);
            end
        end
    end

    always_comb begin
        drq_active = (state == DMA_BURST);
    end

    // R8: a request only starts once a full burst was held
    p_drq_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq_active) |-> $past(count) >= $past(blen));

    // R8: mode 00 withdraws the request on the next cycle
    p_drq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode == 2'b00) |=> !drq_active);
endmodule

// File: rtl/frame_byte_fifo.sv
module frame_byte_fifo #(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned BURST_BASE = 8,
    localparam int unsigned AW        = $clog2(DEPTH),
    localparam int unsigned CW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic          ctrl_wr,
    input  logic [7:0]    ctrl_wdata,
    output logic [7:0]    ctrl_rdata,
    input  logic          thr_wr,
    input  logic [AW-1:0] thr_wdata,
    input  logic          clr_wr,
    input  logic [7:0]    clr_wdata,
    output logic [CW-1:0] fill_level,
    output logic          err_flag,
    output logic          irq_o,
    output logic          drq_o,
    output logic          drq_oe
);
    logic       soft_clr, flush, rd_pop, drop_err, ovf_err;
    logic       irq_active, irq_pol, drq_pol, drq_active;
    logic [1:0] dma_mode;

    ffb_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .soft_clr    (soft_clr),
        .rd_data     (rd_data),
        .count       (fill_level),
        .flush       (flush),
        .rd_pop      (rd_pop),
        .drop_err    (drop_err),
        .ovf_err     (ovf_err)
    );

    ffb_regs #(.DEPTH(DEPTH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .thr_wr      (thr_wr),
        .thr_wdata   (thr_wdata),
        .clr_wr      (clr_wr),
        .clr_wdata   (clr_wdata),
        .drop_err    (drop_err),
        .ovf_err     (ovf_err),
        .count       (fill_level),
        .ctrl_rdata  (ctrl_rdata),
        .soft_clr    (soft_clr),
        .err_flag    (err_flag),
        .irq_active  (irq_active),
        .irq_pol     (irq_pol),
        .drq_pol     (drq_pol),
        .dma_mode    (dma_mode)
    );

    ffb_dma #(.DEPTH(DEPTH), .BURST_BASE(BURST_BASE)) u_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_mode    (dma_mode),
        .count       (fill_level),
        .rd_pop      (rd_pop),
        .flush       (flush),
        .drq_active  (drq_active)
    );

    always_comb begin
        irq_o  = irq_active ^ irq_pol;
        drq_o  = drq_active ^ drq_pol;
        drq_oe = (dma_mode != 2'b00);
    end

    // R5: a full buffer with an unpaired write raises the error flag
    p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && frame_valid && !rd_en && !flush && fill_level == CW'(DEPTH))
        |=> err_flag && fill_level == CW'(DEPTH));
endmodule

// File: tb/frame_byte_fifo_tb.sv
module frame_byte_fifo_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_valid, wr_en, rd_en, ctrl_wr, thr_wr, clr_wr;
    logic [7:0] wr_data, ctrl_wdata, clr_wdata;
    logic [5:0] thr_wdata;
    logic [7:0] rd_data, ctrl_rdata;
    logic [6:0] fill_level;
    logic       err_flag, irq_o, drq_o, drq_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_byte_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .clr_wr(clr_wr),
        .clr_wdata(clr_wdata), .fill_level(fill_level), .err_flag(err_flag),
        .irq_o(irq_o), .drq_o(drq_o), .drq_oe(drq_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic clr(input logic [7:0] v);
        clr_wr = 1'b1; clr_wdata = v;
        @(negedge clk);
        clr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("reset R1 fill_level", fill_level, 0);
        chk("reset R6 err_flag", err_flag, 0);
        chk("reset R9 ctrl_rdata", ctrl_rdata, 0);
        chk("reset R7 irq_o", irq_o, 0);
        chk("reset R8 drq_oe", drq_oe, 0);
    endtask

    task automatic t_order();
        frame_valid = 1'b1; idle(1);
        chk("R4 start on empty buffer keeps err", err_flag, 0);
        push(8'hA1); push(8'hB2); push(8'hC3);
        chk("R1 count after 3 writes", fill_level, 3);
        pop(); chk("R1 first pop", rd_data, 8'hA1); chk("R1 count", fill_level, 2);
        pop(); chk("R1 second pop", rd_data, 8'hB2);
        pop(); chk("R1 third pop", rd_data, 8'hC3); chk("R1 count", fill_level, 0);
    endtask

    task automatic t_empty();
        pop();
        chk("R2 empty pop repeats byte", rd_data, 8'hC3);
        chk("R2 empty pop count", fill_level, 0);
    endtask

    task automatic t_gate();
        frame_valid = 1'b0; idle(1);
        push(8'h55);
        chk("R3 write outside envelope", fill_level, 0);
        frame_valid = 1'b1; idle(1);
        chk("R4 start on empty buffer", err_flag, 0);
    endtask

    task automatic t_flush();
        push(8'h11); push(8'h22);
        frame_valid = 1'b0; idle(1);
        frame_valid = 1'b1; idle(1);
        chk("R4 leftover discarded", fill_level, 0);
        chk("R4 leftover sets err", err_flag, 1);
        clr(8'h00);
        chk("R6 clear without bit0", err_flag, 1);
        clr(8'h01);
        chk("R6 clear with bit0", err_flag, 0);
        frame_valid = 1'b0; idle(1);
        frame_valid = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 byte on start edge kept", fill_level, 1);
        chk("R4 empty start no err", err_flag, 0);
        pop();
        chk("R4 byte on start edge data", rd_data, 8'h77);
    endtask

    task automatic t_full();
        for (int i = 0; i < 64; i++) push(8'h40 + 8'(i));
        chk("R5 full count", fill_level, 64);
        chk("R5 no err when just full", err_flag, 0);
        push(8'hEE);
        chk("R5 overflow count", fill_level, 64);
        chk("R5 overflow err", err_flag, 1);
        clr(8'h01);
        wr_en = 1'b1; wr_data = 8'h99; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 simul at full count", fill_level, 64);
        chk("R10 simul at full err", err_flag, 0);
        chk("R10 simul at full data", rd_data, 8'h40);
        ctrl(8'h01);
        chk("R9 control flush count", fill_level, 0);
        chk("R9 control flush no err", err_flag, 0);
        chk("R9 flush bit reads zero", ctrl_rdata, 0);
        push(8'h3C);
        wr_en = 1'b1; wr_data = 8'h5A; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 simul mid count", fill_level, 1);
        chk("R10 simul mid data", rd_data, 8'h3C);
        pop();
        chk("R10 paired write stored", rd_data, 8'h5A);
    endtask

    task automatic t_irq();
        thr_wr = 1'b1; thr_wdata = 6'd4;
        @(negedge clk);
        thr_wr = 1'b0;
        push(8'h01); push(8'h02); push(8'h03);
        chk("R7 below threshold", irq_o, 0);
        push(8'h04);
        chk("R7 at threshold", irq_o, 1);
        pop();
        chk("R7 drop below threshold", irq_o, 0);
        ctrl(8'h20);
        chk("R7 polarity readback", ctrl_rdata, 8'h20);
        chk("R7 inverted idle", irq_o, 1);
        ctrl(8'h01);
        chk("R9 clear resets polarity and count", fill_level, 0);
    endtask

    task automatic t_reserved();
        ctrl(8'hFF);
        chk("R9 reserved read zero", ctrl_rdata, 8'h3C);
        ctrl(8'h00);
    endtask

    task automatic t_dma();
        ctrl(8'h04);
        chk("R8 enable drives pin", drq_oe, 1);
        chk("R8 idle request", drq_o, 0);
        for (int i = 0; i < 7; i++) push(8'(i));
        idle(1);
        chk("R8 no request below burst", drq_o, 0);
        push(8'h07); idle(1);
        chk("R8 request at burst 8", drq_o, 1);
        for (int i = 0; i < 7; i++) pop();
        chk("R8 request held in burst", drq_o, 1);
        pop();
        chk("R8 request ends after 8", drq_o, 0);
        chk("R8 count after burst", fill_level, 0);
        ctrl(8'h14);
        chk("R8 inverted idle", drq_o, 1);
        ctrl(8'h0C);
        for (int i = 0; i < 31; i++) push(8'(i));
        idle(1);
        chk("R8 no request below 32", drq_o, 0);
        push(8'hFF); idle(1);
        chk("R8 request at burst 32", drq_o, 1);
        ctrl(8'h0D);
        chk("R8 flush aborts burst", drq_o, 0);
        chk("R9 flush empties", fill_level, 0);
        chk("R9 flush bit not stored", ctrl_rdata, 8'h0C);
        ctrl(8'h00);
        chk("R8 mode 00 releases pin", drq_oe, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; frame_valid = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        ctrl_wr = 1'b0; thr_wr = 1'b0; clr_wr = 1'b0;
        wr_data = '0; ctrl_wdata = '0; clr_wdata = '0; thr_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty();
        t_gate();
        t_flush();
        t_full();
        t_irq();
        t_reserved();
        t_dma();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end
endmodule